// File: doc/BRIEF.md
# Split-Tenure Bus Master Arbitration

This block is the master side of a processor bus on which the address phase and the data phase are won separately. A transaction start pulse, together with a burst flag and an address-only flag, opens an address tenure. The block raises a request and waits for a grant from an external central arbiter. It takes the grant only when that grant is qualified, and then pulls the shared active-low address-busy line low for as long as it owns the address bus.

The address tenure ends when the system acknowledges the address. If the system signals retry instead, the block releases the bus and arbitrates again. A transaction that carries data then enters a data tenure. The block waits for a qualified data grant and holds the active-low data-busy line low. It counts termination strobes until one beat, or a four-beat burst, is complete. Address-only transactions never start a data tenure.

The busy lines are open-drain style. The block provides a drive-enable output for each line and a sampled input for each line. The system resolves each line as a wired pull-up net. A parked master can take a qualified grant without raising its request.

Top module: `split_bus_master`

## Requirements
- R1: While rst_ni is low, br_o, abb_oe_o, dbb_oe_o, addr_done_o and data_done_o are all 0. This holds immediately, without waiting for a clock.
- R2: Starting in the cycle after an accepted start, br_o is 1 while the address tenure waits for a grant, provided parked_i is 0. br_o is 0 once the address bus is owned.
- R3: abb_oe_o rises on the edge after a cycle in which all of the following held: bg_i was 1, abb_n_i was 1 (bus not busy), artry_i was 0, and artry_i had also been 0 in the cycle before. A grant seen while abb_n_i is 0 is not taken.
- R4: br_o stays 0 while parked_i is 1, and a qualified grant is still taken.
- R5: If artry_i is 1 while the block owns the address bus, the following hold. addr_done_o stays 0. abb_oe_o falls on the next edge. The request returns to the waiting state. A grant in the cycle right after the retry cycle is not taken.
- R6: aack_i while the address bus is owned (and artry_i is 0) gives addr_done_o = 1 in that same cycle. abb_oe_o falls on the next edge.
- R7: A transaction started with addr_only_i = 1 never asserts dbb_oe_o, even if dg_i is 1.
- R8: dbb_oe_o rises only on the edge after a cycle with dg_i = 1 and dbb_n_i = 1, and only after the address tenure of a data transaction has completed.
- R9: A single-beat transfer (burst_i = 0) ends on its first ta_i. data_done_o is 1 in that cycle and dbb_oe_o falls on the next edge.
- R10: A burst (burst_i = 1) holds dbb_oe_o through BEATS = 4 ta_i strobes, including idle cycles between them. data_done_o is 1 only with the fourth strobe, and dbb_oe_o falls on the edge after it.
- R11: start_i is ignored unless both the address side and the data side are idle. A start given during a tenure produces no later request and no bus ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction start pulse |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| addr_only_i | input | 1 | 1 = no data tenure |
| parked_i | input | 1 | Master is parked on the address bus |
| bg_i | input | 1 | Address bus grant from arbiter |
| abb_n_i | input | 1 | Sampled address-busy line, active low |
| artry_i | input | 1 | Address retry |
| aack_i | input | 1 | Address acknowledge, ends address tenure |
| dg_i | input | 1 | Data bus grant from arbiter |
| dbb_n_i | input | 1 | Sampled data-busy line, active low |
| ta_i | input | 1 | Data beat termination |
| br_o | output | 1 | Address bus request |
| abb_oe_o | output | 1 | Drive address-busy low |
| dbb_oe_o | output | 1 | Drive data-busy low |
| addr_done_o | output | 1 | Address tenure completed this cycle |
| data_done_o | output | 1 | Data tenure completed this cycle |

## Verification
Suppose the retry history register were stale or cleared. The block would then take a grant in the cycle right after a retry, and abb_oe_o would show that one edge early. Suppose the beat counter were wrong. Then data_done_o would appear on the wrong strobe, and dbb_oe_o would fall early or late at the edge after that strobe. A stuck address-side state would show up in br_o or abb_oe_o within one cycle of the next grant, and a start that is wrongly accepted during a tenure would show up as a fresh request after the tenure ends.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {A_IDLE, A_REQ, A_OWN} addr_st_e;
  typedef enum logic [1:0] {D_IDLE, D_WAIT, D_OWN} data_st_e;
  typedef struct packed {
    logic burst;
    logic addr_only;
  } txn_attr_t;
endpackage

// File: rtl/sbm_grant_qual.sv
module sbm_grant_qual #(
  parameter bit USE_RETRY = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic busy_n_i,
  input  logic retry_i,
  output logic qual_o
);
  generate
    if (USE_RETRY) begin : g_retry
      logic retry_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) retry_q <= 1'b0;
        else         retry_q <= retry_i;
      end
      assign qual_o = grant_i && busy_n_i && !retry_i && !retry_q;
    end else begin : g_plain
      logic unused_retry;
      assign unused_retry = retry_i ^ clk_i ^ rst_ni;
      assign qual_o = grant_i && busy_n_i;
    end
  endgenerate
endmodule

// File: rtl/sbm_addr_fsm.sv
module sbm_addr_fsm
  import sbm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  txn_attr_t attr_i,
  input  logic      parked_i,
  input  logic      qual_i,
  input  logic      aack_i,
  input  logic      artry_i,
  output logic      br_o,
  output logic      own_o,
  output logic      done_o,
  output logic      data_go_o,
  output txn_attr_t attr_o,
  output logic      idle_o
);
  addr_st_e  st_q, st_d;
  txn_attr_t attr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      A_IDLE: if (accept_i) st_d = A_REQ;
      A_REQ:  if (qual_i) st_d = A_OWN;
      A_OWN: begin
        if (artry_i)     st_d = A_REQ;   // retry wins over ack
        else if (aack_i) st_d = A_IDLE;
      end
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= A_IDLE;
      attr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept_i) attr_q <= attr_i;
    end
  end

  assign br_o      = (st_q == A_REQ) && !parked_i;
  assign own_o     = (st_q == A_OWN);
  assign done_o    = own_o && aack_i && !artry_i;
  assign data_go_o = done_o && !attr_q.addr_only;
  assign attr_o    = attr_q;
  assign idle_o    = (st_q == A_IDLE);
endmodule

// File: rtl/sbm_data_fsm.sv
module sbm_data_fsm
  import sbm_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic burst_i,
  input  logic qual_i,
  input  logic ta_i,
  output logic own_o,
  output logic done_o,
  output logic idle_o
);
  data_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             burst_q;
  logic             last;

  assign last = !burst_q || (cnt_q == CNT_W'(BEATS - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      D_IDLE: if (go_i) st_d = D_WAIT;
      D_WAIT: if (qual_i) st_d = D_OWN;
      D_OWN:  if (ta_i && last) st_d = D_IDLE;
      default: st_d = D_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= D_IDLE;
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (go_i) burst_q <= burst_i;
      if (st_q == D_WAIT)          cnt_q <= '0;
      else if (own_o && ta_i)      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign own_o  = (st_q == D_OWN);
  assign done_o = own_o && ta_i && last;
  assign idle_o = (st_q == D_IDLE);
endmodule

// File: rtl/split_bus_master.sv
module split_bus_master
  import sbm_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic burst_i,
  input  logic addr_only_i,
  input  logic parked_i,
  input  logic bg_i,
  input  logic abb_n_i,
  input  logic artry_i,
  input  logic aack_i,
  input  logic dg_i,
  input  logic dbb_n_i,
  input  logic ta_i,
  output logic br_o,
  output logic abb_oe_o,
  output logic dbb_oe_o,
  output logic addr_done_o,
  output logic data_done_o
);
  logic      a_qual, d_qual, a_idle, d_idle, accept, data_go;
  txn_attr_t attr_in, attr_q;

  assign attr_in = '{burst: burst_i, addr_only: addr_only_i};
  assign accept  = start_i && a_idle && d_idle;

  sbm_grant_qual #(.USE_RETRY(1'b1)) u_aqual (
    .clk_i, .rst_ni, .grant_i(bg_i), .busy_n_i(abb_n_i),
    .retry_i(artry_i), .qual_o(a_qual)
  );

  sbm_grant_qual #(.USE_RETRY(1'b0)) u_dqual (
    .clk_i, .rst_ni, .grant_i(dg_i), .busy_n_i(dbb_n_i),
    .retry_i(1'b0), .qual_o(d_qual)
  );

  sbm_addr_fsm u_addr (
    .clk_i, .rst_ni, .accept_i(accept), .attr_i(attr_in),
    .parked_i, .qual_i(a_qual), .aack_i, .artry_i,
    .br_o, .own_o(abb_oe_o), .done_o(addr_done_o),
    .data_go_o(data_go), .attr_o(attr_q), .idle_o(a_idle)
  );

  sbm_data_fsm #(.BEATS(BEATS)) u_data (
    .clk_i, .rst_ni, .go_i(data_go), .burst_i(attr_q.burst),
    .qual_i(d_qual), .ta_i, .own_o(dbb_oe_o),
    .done_o(data_done_o), .idle_o(d_idle)
  );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int BEATS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic parked_i,
  input logic bg_i,
  input logic abb_n_i,
  input logic artry_i,
  input logic aack_i,
  input logic dg_i,
  input logic dbb_n_i,
  input logic ta_i,
  input logic br_o,
  input logic abb_oe_o,
  input logic dbb_oe_o,
  input logic data_done_o
);
  logic       artry_d;
  logic [7:0] beats;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      artry_d <= 1'b0;
      beats   <= '0;
    end else begin
      artry_d <= artry_i;
      if (dbb_oe_o && ta_i) beats <= data_done_o ? '0 : beats + 1'b1;
    end
  end

  p_grant_qual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abb_oe_o) |-> $past(bg_i && abb_n_i && !artry_i && !artry_d));

  p_parked_no_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_i |-> !br_o);

  p_retry_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abb_oe_o && artry_i) |=> !abb_oe_o);

  p_ack_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abb_oe_o && aack_i) |=> !abb_oe_o);

  p_data_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbb_oe_o) |-> $past(dg_i && dbb_n_i));

  p_single_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_done_o |=> !dbb_oe_o);

  p_beat_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_done_o |-> (beats == 8'd0 || beats == 8'(BEATS - 1)));
endmodule

bind split_bus_master sbm_checker #(.BEATS(BEATS)) u_sbm_chk (
  .clk_i, .rst_ni, .parked_i, .bg_i, .abb_n_i, .artry_i, .aack_i,
  .dg_i, .dbb_n_i, .ta_i, .br_o, .abb_oe_o, .dbb_oe_o, .data_done_o
);

// File: tb/split_bus_master_bench.sv
module split_bus_master_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 0, burst = 0, ao = 0, parked = 0, bg = 0, artry = 0, aack = 0;
  logic dg = 0, ta = 0, ext_abb = 0, ext_dbb = 0;
  logic br, abb_oe, dbb_oe, addr_done, data_done, abb_n, dbb_n;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  // wired pull-up busy nets
  assign abb_n = !(abb_oe || ext_abb);
  assign dbb_n = !(dbb_oe || ext_dbb);

  split_bus_master u_split_bus_master (
    .clk_i(clk), .rst_ni, .start_i(start), .burst_i(burst), .addr_only_i(ao),
    .parked_i(parked), .bg_i(bg), .abb_n_i(abb_n), .artry_i(artry),
    .aack_i(aack), .dg_i(dg), .dbb_n_i(dbb_n), .ta_i(ta),
    .br_o(br), .abb_oe_o(abb_oe), .dbb_oe_o(dbb_oe),
    .addr_done_o(addr_done), .data_done_o(data_done)
  );

  // {exp_beats[2:0], burst, addr_only, parked, retry, data_busy}
  localparam logic [7:0] VEC [7] = '{
    8'b001_00000, 8'b100_10000, 8'b000_01000, 8'b001_00110,
    8'b100_10011, 8'b000_01110, 8'b100_10101
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [7:0] v);
    logic pk;
    int   nb;
    pk = v[2];
    nb = int'(v[7:5]);
    @(negedge clk);
    parked = pk; start = 1; burst = v[4]; ao = v[3];
    @(negedge clk);
    start = 0;
    #1;
    chk(pk ? "R4 parked no request" : "R2 request raised", br, !pk);
    chk("R3 not owned before grant", abb_oe, 1'b0);
    ext_abb = 1; bg = 1; dg = 1;
    @(negedge clk); #1;
    chk("R3 grant while busy ignored", abb_oe, 1'b0);
    chk("R8 no data grant before address done", dbb_oe, 1'b0);
    ext_abb = 0; dg = 0;
    @(negedge clk); #1;
    chk("R3 qualified grant taken", abb_oe, 1'b1);
    chk("R2 request drops when owned", br, 1'b0);
    bg = 0;
    if (v[1]) begin
      artry = 1; #1;
      chk("R5 no done on retry", addr_done, 1'b0);
      @(negedge clk);
      artry = 0; bg = 1; #1;
      chk("R5 release after retry", abb_oe, 1'b0);
      chk("R5 re-request", br, !pk);
      @(negedge clk); #1;
      chk("R5 previous-cycle retry blocks grant", abb_oe, 1'b0);
      @(negedge clk); #1;
      chk("R5 re-grant", abb_oe, 1'b1);
      bg = 0;
    end
    aack = 1; #1;
    chk("R6 address done", addr_done, 1'b1);
    @(negedge clk);
    aack = 0; #1;
    chk("R6 address released", abb_oe, 1'b0);
    if (v[3]) begin
      dg = 1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); #1;
        chk("R7 address-only has no data tenure", dbb_oe, 1'b0);
      end
      dg = 0;
      chk("R7 idle after address-only", br, 1'b0);
    end else begin
      ext_dbb = v[0]; dg = 1; start = 1;   // R11 start ignored
      @(negedge clk);
      start = 0;
      if (v[0]) begin
        #1 chk("R8 data grant while busy ignored", dbb_oe, 1'b0);
        ext_dbb = 0;
        @(negedge clk);
      end
      #1 chk("R8 data bus owned", dbb_oe, 1'b1);
      dg = 0;
      for (int i = 0; i < nb; i++) begin
        ta = 1; #1;
        chk(nb == 1 ? "R9 done on single beat" : "R10 done on last beat",
            data_done, i == nb - 1);
        @(negedge clk);
        ta = 0; #1;
        chk(nb == 1 ? "R9 release after beat" : "R10 hold until last beat",
            dbb_oe, i != nb - 1);
        if (i == 1) begin
          @(negedge clk); #1;
          chk("R10 hold across gap", dbb_oe, 1'b1);
        end
      end
      chk("R11 ignored start raises no request", br, 1'b0);
      @(negedge clk); #1;
      chk("R11 no ownership after ignored start", abb_oe, 1'b0);
      chk("R11 still no request", br, 1'b0);
    end
    parked = 0;
  endtask

  initial begin
    #1;
    chk("R1 reset br", br, 1'b0);
    chk("R1 reset abb", abb_oe, 1'b0);
    chk("R1 reset dbb", dbb_oe, 1'b0);
    chk("R1 reset done", data_done | addr_done, 1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    foreach (VEC[k]) run_txn(VEC[k]);
    // R4: parked, grant taken with request low throughout
    @(negedge clk);
    parked = 1; start = 1; burst = 0; ao = 1;
    @(negedge clk);
    start = 0; bg = 1; #1;
    chk("R4 parked no request", br, 1'b0);
    @(negedge clk); #1;
    chk("R4 parked grant taken", abb_oe, 1'b1);
    bg = 0;
    // R1: asynchronous reset during tenure
    rst_ni = 0; #1;
    chk("R1 async reset abb", abb_oe, 1'b0);
    chk("R1 async reset br", br, 1'b0);
    parked = 0;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk); #1;
    chk("R1 idle after reset", br, 1'b0);
    chk("R1 no ownership after reset", abb_oe, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule